// File: doc/BRIEF.md
# Shared Controller Ownership Arbiter

This block arbitrates a single disk controller that is shared by two client subsystems: a diskette client (client 0) and a tape client (client 1). Each client may ask to claim or to release the right to receive the controller's interrupt. The block holds that right as one exclusive lock and answers every request with a single-cycle success or failure pulse. Controller interrupts are steered only to the client holding the lock. When no client holds it, an interrupt is thrown away.

The block also stores two status-byte counts: one for interrupt status and one for command status. Neighbouring logic loads these counts. Every controller interrupt forces both counts back to zero, so a stale count can never be read against a fresh interrupt.

A second, independent interface lets each client switch its own periodic-timer bit on or off. While any bit is set, a shared tick-enable output stays high, which asks the tick source to keep running. Each incoming tick is copied only to the clients whose bit is set. Both the client count and the count width are parameters.

Top module: `ctl_share_arbiter`

## Requirements
- R1: A claim from a client arriving while no client owns the lock succeeds: in the next cycle that client's `req_ok` bit pulses and the client becomes the owner.
- R2: A claim arriving while some client owns the lock fails: in the next cycle the claimant's `req_fail` bit pulses and ownership is unchanged.
- R3: When both clients claim in the same cycle and the lock is free, client 0 (the diskette client, bit 0) wins with `req_ok[0]`, and client 1 gets `req_fail[1]`.
- R4: A release from the current owner succeeds: `req_ok` pulses for that client in the next cycle and the lock becomes free.
- R5: A release from a client that does not own the lock fails with a `req_fail` pulse, whether or not another client owns it, and ownership is unchanged.
- R6: Ownership is judged on the state at the start of the cycle, so a claim made in the same cycle as the owner's release fails. A client asserting claim and release together gets `req_fail` and changes nothing. Each pulse on `req_ok` or `req_fail` lasts exactly one cycle, and no bit pulses without a request.
- R7: A cycle with `ctl_irq` high makes `irq_out` equal the owner's one-hot bit in the next cycle. The interrupt is dropped (`irq_out` = 0) when there is no owner, and `irq_out` is 0 after any cycle without `ctl_irq`.
- R8: A write strobe loads `int_cnt` or `cmd_cnt` in the next cycle. A cycle with `ctl_irq` high clears both counts at the same edge that raises `irq_out`, overriding any write in that cycle.
- R9: `tmr_on_req[i]` sets client i's timer bit. `tmr_off_req[i]` clears it. `tick_en` is high in every cycle after at least one bit is set and low only once every bit is clear.
- R10: A timer request that would not change the client's bit has no effect, and neither does asserting on and off together. This covers turning on a bit that is already on and turning off a bit that is already off.
- R11: A cycle with `tick_in` high makes `tick_out` equal the timer bits held in that cycle, one cycle later. A timer request in the same cycle does not affect that tick. `tick_out` is 0 after any cycle without a tick.
- R12: The synchronous reset `rst` frees the lock, clears both timer bits and both counts, and drives `tick_en`, `req_ok`, `req_fail`, `irq_out` and `tick_out` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| claim_req | input | NCLI | Per-client claim request, bit 0 diskette, bit 1 tape |
| release_req | input | NCLI | Per-client release request |
| req_ok | output | NCLI | One-cycle success pulse per client |
| req_fail | output | NCLI | One-cycle failure pulse per client |
| ctl_irq | input | 1 | Interrupt from the shared controller |
| irq_out | output | NCLI | Interrupt forwarded to the owning client |
| int_cnt_wr | input | 1 | Load strobe for the interrupt-status count |
| int_cnt_din | input | CNT_W | Value loaded into the interrupt-status count |
| cmd_cnt_wr | input | 1 | Load strobe for the command-status count |
| cmd_cnt_din | input | CNT_W | Value loaded into the command-status count |
| int_cnt | output | CNT_W | Stored interrupt-status count |
| cmd_cnt | output | CNT_W | Stored command-status count |
| tmr_on_req | input | NCLI | Per-client timer enable request |
| tmr_off_req | input | NCLI | Per-client timer disable request |
| tick_in | input | 1 | Shared periodic tick |
| tick_out | output | NCLI | Tick forwarded to clients with their timer bit set |
| tick_en | output | 1 | High while any timer bit is set |

## Verification
A vector walk drives the lock through several kinds of request: a claim on a free lock, a claim on a held lock, a release by a non-owner, a release with no owner, simultaneous claims, a release paired with a rival's claim, and a conflicting claim-plus-release. Interrupts are placed between these requests, so the same interrupt shows each owner in turn and is also shown being dropped. The timer sequence turns the bits on and off in an order that separates "any bit set" from "the last bit set". It also includes redundant requests and a tick that coincides with a request. Count writes that collide with an interrupt show which of the two has priority, and a reset in mid-run shows that the lock and timers really clear.

// File: rtl/arb_pkg.sv
package arb_pkg;
  localparam int DISK_ID = 0;
  localparam int TAPE_ID = 1;

  // Next state of one timer bit: only an unambiguous request moves it.
  function automatic logic timer_next(logic cur, logic on, logic off);
    if (on && !off) return 1'b1;
    if (off && !on) return 1'b0;
    return cur;
  endfunction
endpackage

// File: rtl/arb_own_lock.sv
module arb_own_lock #(
  parameter int NCLI = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLI-1:0] claim_req,
  input  logic [NCLI-1:0] release_req,
  output logic [NCLI-1:0] owner,
  output logic [NCLI-1:0] req_ok,
  output logic [NCLI-1:0] req_fail
);
  // Lowest set bit wins: isolates it by two's complement.
  function automatic logic [NCLI-1:0] lowest_bit(logic [NCLI-1:0] v);
    return v & (~v + {{(NCLI-1){1'b0}}, 1'b1});
  endfunction

  logic [NCLI-1:0] clean_claim, clean_rel, conflict;
  logic [NCLI-1:0] rel_hit, rel_miss, grant, deny;
  logic            lock_free, grant_evt, release_evt;
  logic [NCLI-1:0] owner_nxt;

  assign conflict    = claim_req & release_req;
  assign clean_claim = claim_req & ~release_req;
  assign clean_rel   = release_req & ~claim_req;
  assign lock_free   = (owner == '0);
  assign rel_hit     = clean_rel & owner;
  assign rel_miss    = clean_rel & ~owner;
  assign grant       = lock_free ? lowest_bit(clean_claim) : '0;
  assign deny        = clean_claim & ~grant;
  assign grant_evt   = |grant;
  assign release_evt = |rel_hit;

  always_comb begin
    owner_nxt = owner;
    if (release_evt)    owner_nxt = '0;
    else if (grant_evt) owner_nxt = grant;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      owner    <= '0;
      req_ok   <= '0;
      req_fail <= '0;
    end else begin
      owner    <= owner_nxt;
      req_ok   <= grant | rel_hit;
      req_fail <= deny | rel_miss | conflict;
    end
  end

  a_r6_owner_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(owner));
  a_r6_ok_fail_excl: assert property (@(posedge clk) disable iff (rst)
    (req_ok & req_fail) == '0);
  a_r2_claim_held_fails: assert property (@(posedge clk) disable iff (rst)
    (owner != '0 && claim_req != '0 && release_req == '0) |=>
      (owner == $past(owner) && (req_fail & $past(claim_req)) == $past(claim_req)));
  a_r12_reset_clears_lock: assert property (@(posedge clk)
    rst |=> (owner == '0 && req_ok == '0 && req_fail == '0));

  generate
    for (genvar i = 0; i < NCLI; i++) begin : g_cli
      a_r4_owner_release: assert property (@(posedge clk) disable iff (rst)
        (owner[i] && release_req[i] && !claim_req[i]) |=> (owner == '0 && req_ok[i]));
      a_r5_foreign_release: assert property (@(posedge clk) disable iff (rst)
        (!owner[i] && release_req[i] && !claim_req[i]) |=> req_fail[i]);
      a_r6_quiet_no_pulse: assert property (@(posedge clk) disable iff (rst)
        (!claim_req[i] && !release_req[i]) |=> (!req_ok[i] && !req_fail[i]));
    end
    if (NCLI >= 2) begin : g_prio
      a_r1_free_claim_disk: assert property (@(posedge clk) disable iff (rst)
        (owner == '0 && claim_req[0] && !release_req[0]) |=> (owner[0] && req_ok[0]));
      a_r3_disk_priority: assert property (@(posedge clk) disable iff (rst)
        (owner == '0 && claim_req[0] && claim_req[1] && release_req[1:0] == 2'b00)
          |=> (owner[0] && req_fail[1]));
    end
  endgenerate
endmodule

// File: rtl/arb_irq_route.sv
module arb_irq_route #(
  parameter int NCLI  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCLI-1:0]  owner,
  input  logic             ctl_irq,
  input  logic             int_cnt_wr,
  input  logic [CNT_W-1:0] int_cnt_din,
  input  logic             cmd_cnt_wr,
  input  logic [CNT_W-1:0] cmd_cnt_din,
  output logic [NCLI-1:0]  irq_out,
  output logic [CNT_W-1:0] int_cnt,
  output logic [CNT_W-1:0] cmd_cnt
);
  // Count update: interrupt invalidates, otherwise a write loads.
  function automatic logic [CNT_W-1:0] count_next(logic irq, logic wr,
                                                  logic [CNT_W-1:0] din,
                                                  logic [CNT_W-1:0] cur);
    if (irq) return '0;
    if (wr)  return din;
    return cur;
  endfunction

  logic [NCLI-1:0] route_evt;
  assign route_evt = ctl_irq ? owner : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_out <= '0;
      int_cnt <= '0;
      cmd_cnt <= '0;
    end else begin
      irq_out <= route_evt;
      int_cnt <= count_next(ctl_irq, int_cnt_wr, int_cnt_din, int_cnt);
      cmd_cnt <= count_next(ctl_irq, cmd_cnt_wr, cmd_cnt_din, cmd_cnt);
    end
  end

  a_r7_irq_to_owner: assert property (@(posedge clk) disable iff (rst)
    ctl_irq |=> irq_out == $past(owner));
  a_r7_no_irq_quiet: assert property (@(posedge clk) disable iff (rst)
    !ctl_irq |=> irq_out == '0);
  a_r8_irq_clears_counts: assert property (@(posedge clk) disable iff (rst)
    ctl_irq |=> (int_cnt == '0 && cmd_cnt == '0));
  a_r8_write_loads: assert property (@(posedge clk) disable iff (rst)
    (!ctl_irq && int_cnt_wr) |=> int_cnt == $past(int_cnt_din));
endmodule

// File: rtl/arb_tick_gate.sv
module arb_tick_gate #(
  parameter int NCLI = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCLI-1:0] tmr_on_req,
  input  logic [NCLI-1:0] tmr_off_req,
  input  logic            tick_in,
  output logic [NCLI-1:0] tick_out,
  output logic            tick_en
);
  import arb_pkg::*;

  logic [NCLI-1:0] tmr_bits, tmr_nxt;

  generate
    for (genvar i = 0; i < NCLI; i++) begin : g_bit
      assign tmr_nxt[i] = timer_next(tmr_bits[i], tmr_on_req[i], tmr_off_req[i]);

      a_r9_on_enables: assert property (@(posedge clk) disable iff (rst)
        (tmr_on_req[i] && !tmr_off_req[i]) |=> (tick_en && tmr_bits[i]));
      a_r10_redundant_off: assert property (@(posedge clk) disable iff (rst)
        (!tmr_bits[i] && !tmr_on_req[i]) |=> !tmr_bits[i]);
      a_r10_both_ignored: assert property (@(posedge clk) disable iff (rst)
        (tmr_on_req[i] && tmr_off_req[i]) |=> tmr_bits[i] == $past(tmr_bits[i]));
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      tmr_bits <= '0;
      tick_out <= '0;
    end else begin
      tmr_bits <= tmr_nxt;
      tick_out <= tick_in ? tmr_bits : '0;
    end
  end

  assign tick_en = |tmr_bits;

  a_r11_tick_forward: assert property (@(posedge clk) disable iff (rst)
    tick_in |=> tick_out == $past(tmr_bits));
  a_r11_no_tick_quiet: assert property (@(posedge clk) disable iff (rst)
    !tick_in |=> tick_out == '0);
  a_r12_reset_timers: assert property (@(posedge clk)
    rst |=> (!tick_en && tick_out == '0));
endmodule

// File: rtl/ctl_share_arbiter.sv
module ctl_share_arbiter #(
  parameter int NCLI  = 2,
  parameter int CNT_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCLI-1:0]  claim_req,
  input  logic [NCLI-1:0]  release_req,
  output logic [NCLI-1:0]  req_ok,
  output logic [NCLI-1:0]  req_fail,
  input  logic             ctl_irq,
  output logic [NCLI-1:0]  irq_out,
  input  logic             int_cnt_wr,
  input  logic [CNT_W-1:0] int_cnt_din,
  input  logic             cmd_cnt_wr,
  input  logic [CNT_W-1:0] cmd_cnt_din,
  output logic [CNT_W-1:0] int_cnt,
  output logic [CNT_W-1:0] cmd_cnt,
  input  logic [NCLI-1:0]  tmr_on_req,
  input  logic [NCLI-1:0]  tmr_off_req,
  input  logic             tick_in,
  output logic [NCLI-1:0]  tick_out,
  output logic             tick_en
);
  logic [NCLI-1:0] owner;

  arb_own_lock #(.NCLI(NCLI)) u_lock (
    .clk(clk), .rst(rst), .claim_req(claim_req), .release_req(release_req),
    .owner(owner), .req_ok(req_ok), .req_fail(req_fail)
  );

  arb_irq_route #(.NCLI(NCLI), .CNT_W(CNT_W)) u_route (
    .clk(clk), .rst(rst), .owner(owner), .ctl_irq(ctl_irq),
    .int_cnt_wr(int_cnt_wr), .int_cnt_din(int_cnt_din),
    .cmd_cnt_wr(cmd_cnt_wr), .cmd_cnt_din(cmd_cnt_din),
    .irq_out(irq_out), .int_cnt(int_cnt), .cmd_cnt(cmd_cnt)
  );

  arb_tick_gate #(.NCLI(NCLI)) u_tick (
    .clk(clk), .rst(rst), .tmr_on_req(tmr_on_req), .tmr_off_req(tmr_off_req),
    .tick_in(tick_in), .tick_out(tick_out), .tick_en(tick_en)
  );
endmodule

// File: tb/ctl_share_arbiter_bench.sv
module ctl_share_arbiter_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] claim_req, release_req, tmr_on_req, tmr_off_req;
  logic       ctl_irq, int_cnt_wr, cmd_cnt_wr, tick_in;
  logic [2:0] int_cnt_din, cmd_cnt_din;
  logic [1:0] req_ok, req_fail, irq_out, tick_out;
  logic [2:0] int_cnt, cmd_cnt;
  logic       tick_en;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  ctl_share_arbiter u_ctl_share_arbiter (
    .clk(clk), .rst(rst), .claim_req(claim_req), .release_req(release_req),
    .req_ok(req_ok), .req_fail(req_fail), .ctl_irq(ctl_irq), .irq_out(irq_out),
    .int_cnt_wr(int_cnt_wr), .int_cnt_din(int_cnt_din),
    .cmd_cnt_wr(cmd_cnt_wr), .cmd_cnt_din(cmd_cnt_din),
    .int_cnt(int_cnt), .cmd_cnt(cmd_cnt), .tmr_on_req(tmr_on_req),
    .tmr_off_req(tmr_off_req), .tick_in(tick_in), .tick_out(tick_out),
    .tick_en(tick_en)
  );

  // {claim, release, irq, exp_ok, exp_fail, exp_irq_out}
  localparam int NV = 15;
  localparam logic [10:0] VEC [NV] = '{
    11'b01_00_0_01_00_00, // R1 claim on free lock
    11'b00_00_1_00_00_01, // R7 irq to owner 0
    11'b10_00_0_00_10_00, // R2 claim on held lock
    11'b00_10_0_00_10_00, // R5 release by non-owner
    11'b00_00_1_00_00_01, // R2 owner unchanged
    11'b00_01_0_01_00_00, // R4 owner release
    11'b00_00_1_00_00_00, // R7 dropped with no owner
    11'b00_01_0_00_01_00, // R5 release with no owner
    11'b11_00_0_01_10_00, // R3 simultaneous claims
    11'b10_01_0_01_10_00, // R6 claim during owner release
    11'b10_00_0_10_00_00, // R1 tape claim on free lock
    11'b00_00_1_00_00_10, // R7 irq to owner 1
    11'b01_01_0_00_01_00, // R6 conflicting request
    11'b00_10_0_10_00_00, // R4 tape release
    11'b00_00_0_00_00_00  // R6 no stray pulses
  };

  task automatic step;
    @(posedge clk);
    #1;
  endtask

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle;
    claim_req = 0; release_req = 0; ctl_irq = 0; int_cnt_wr = 0; cmd_cnt_wr = 0;
    int_cnt_din = 0; cmd_cnt_din = 0; tmr_on_req = 0; tmr_off_req = 0; tick_in = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    idle();
    rst = 1'b1;
    repeat (3) step();
    check("R12 reset ok/fail", {28'd0, req_ok, req_fail}, 32'd0);
    check("R12 reset irq/tick", {28'd0, irq_out, tick_out}, 32'd0);
    check("R12 reset en/cnt", {25'd0, tick_en, int_cnt, cmd_cnt}, 32'd0);
    rst = 1'b0;
    step();

    for (int k = 0; k < NV; k++) begin
      {claim_req, release_req, ctl_irq} = VEC[k][10:6];
      step();
      check($sformatf("R1..R7 vec%0d ok", k), {30'd0, req_ok}, {30'd0, VEC[k][5:4]});
      check($sformatf("R1..R7 vec%0d fail", k), {30'd0, req_fail}, {30'd0, VEC[k][3:2]});
      check($sformatf("R7 vec%0d irq", k), {30'd0, irq_out}, {30'd0, VEC[k][1:0]});
    end
    idle();

    // R8 count loads and irq override
    int_cnt_wr = 1; int_cnt_din = 3'd5; cmd_cnt_wr = 1; cmd_cnt_din = 3'd6;
    step();
    check("R8 int_cnt load", {29'd0, int_cnt}, 32'd5);
    check("R8 cmd_cnt load", {29'd0, cmd_cnt}, 32'd6);
    int_cnt_din = 3'd7; cmd_cnt_din = 3'd7; ctl_irq = 1;
    step();
    check("R8 irq clears int_cnt", {29'd0, int_cnt}, 32'd0);
    check("R8 irq clears cmd_cnt", {29'd0, cmd_cnt}, 32'd0);
    idle();

    // R9..R11 timers
    tmr_on_req = 2'b01; step(); tmr_on_req = 0;
    check("R9 en after on0", {31'd0, tick_en}, 32'd1);
    tick_in = 1; step(); tick_in = 0;
    check("R11 tick to 0", {30'd0, tick_out}, 32'd1);
    tmr_on_req = 2'b01; tmr_off_req = 2'b10; step(); idle();
    tick_in = 1; step(); tick_in = 0;
    check("R10 redundant requests", {30'd0, tick_out}, 32'd1);
    tmr_on_req = 2'b10; step(); tmr_on_req = 0;
    tick_in = 1; step(); tick_in = 0;
    check("R11 tick to both", {30'd0, tick_out}, 32'd3);
    tmr_off_req = 2'b01; step(); tmr_off_req = 0;
    check("R9 en while one set", {31'd0, tick_en}, 32'd1);
    tick_in = 1; tmr_off_req = 2'b10; step(); idle();
    check("R11 tick uses old bits", {30'd0, tick_out}, 32'd2);
    check("R9 en low all clear", {31'd0, tick_en}, 32'd0);
    tmr_on_req = 2'b01; tmr_off_req = 2'b01; step(); idle();
    check("R10 on+off ignored", {31'd0, tick_en}, 32'd0);
    tick_in = 1; step(); tick_in = 0;
    check("R11 no bits no tick", {30'd0, tick_out}, 32'd0);

    // R12 mid-run reset
    claim_req = 2'b01; tmr_on_req = 2'b11; step(); idle();
    check("R12 pre-reset en", {31'd0, tick_en}, 32'd1);
    rst = 1; step(); rst = 0;
    check("R12 reset drops en", {31'd0, tick_en}, 32'd0);
    claim_req = 2'b10; step(); idle();
    check("R12 lock freed", {30'd0, req_ok}, 32'd2);

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule